// File: doc/BRIEF.md
# Queue-locality silent store detector

This block runs beside an in-order load/store queue and marks stores that would write a value the memory word already holds. No cache read is involved. When a store enters the queue, the block looks only at values the queue already has: the data of an older store to the same word, or the data an older load has brought back for that word. If every byte the new store writes equals the value from that older entry, the new store is flagged silent. A later stage can then drop the write.

Entries are allocated at the tail and retired from the head in program order. Each slot holds one operation, its word address, its byte enables and a captured value. A load's value arrives later through a fill port that names the load's slot. A barrier input discards every captured value. A coherence-invalidate input discards the captured load values and keeps the store values. The silent flag of each slot can be read on a per-slot vector. It stays set until that slot dequeues.

Occupancy is tracked by a three-state controller. `Q_EMPTY` moves to `Q_PART` on an accepted enqueue. `Q_PART` moves to `Q_FULL` when an enqueue without a dequeue fills the last slot. `Q_PART` moves back to `Q_EMPTY` when a dequeue without an enqueue removes the last entry. `Q_FULL` returns to `Q_PART` on any dequeue. In all other cases the state holds.

Top module: `lsq_silent_detect`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), `enq_ready`=1, and `silent_vec` is all zero.
- R2: A store is flagged silent when its source is an older store to the same word that enables every byte the new store enables, and the two stores have equal data on those bytes. The source is the youngest older valid entry that shares the word address and at least one enabled byte. The flag for the store's slot (`enq_slot` when it was accepted) reads 1 on `silent_vec` from the clock edge that accepts the store.
- R3: A store is also flagged silent when its source is an older load that has been filled, that covers every byte of the store, and whose fill data equals the store data on the store's enabled bytes.
- R4: If any byte enabled by the new store differs from the source value, the store is not flagged.
- R5: Only the youngest overlapping older entry is used as the source. A younger store with different data hides an older matching store.
- R6: A source that does not enable every byte of the new store gives no silent verdict. Older entries with no byte in common with the new store are skipped in the search. Byte lane b is data bits [8b+7:8b], and enable bit b selects it.
- R7: Loads are never flagged. A load that has not been filled gives no value, and it still acts as the source that hides older entries. `coh_inval` discards the values of loads in the queue, and store values survive it.
- R8: `barrier_flush` discards every value captured so far, including the value of any entry already being compared in that cycle. An enqueue in the same cycle as the flush is never flagged. Flags already set are kept.
- R9: A flag stays with its slot until that slot dequeues. `deq_valid` retires the head entry, and `deq_silent` shows the head's flag in FIFO order. An empty queue has no flag set.
- R10: The queue holds DEPTH entries (32 by default). When full, `q_full`=1 and `enq_ready`=0, and an enqueue attempt changes nothing.
- R11: A fill aimed at a slot that holds a store is ignored, and the store keeps its own data as its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Queue can accept an entry |
| enq_is_store | input | 1 | 1 = store, 0 = load |
| enq_waddr | input | WADDR_W | Word address |
| enq_be | input | BYTES | Byte enables |
| enq_data | input | 8*BYTES | Store data (unused for loads) |
| enq_slot | output | log2(DEPTH) | Slot the next accepted entry occupies |
| fill_valid | input | 1 | A load's returned data is present |
| fill_slot | input | log2(DEPTH) | Slot of the load being filled |
| fill_data | input | 8*BYTES | Data the load returned |
| deq_valid | input | 1 | Retire the head entry |
| deq_silent | output | 1 | Silent flag of the head entry |
| barrier_flush | input | 1 | Discard all captured values |
| coh_inval | input | 1 | Discard captured load values |
| silent_vec | output | DEPTH | Per-slot silent flags |
| q_empty | output | 1 | Queue is empty |
| q_full | output | 1 | Queue is full |

## Verification
The bench builds chains of accesses to one word in which the right verdict depends on choosing the correct older entry. One chain has a matching store hidden behind a younger store with different data. Another has a partial-width store placed in front of a full-width one, and another has a non-overlapping store placed between two matches. A design that searched oldest-first, or that accepted any match, would flag stores that should write. A design that ignored byte coverage would flag a store whose extra bytes were never known. Other cases cover an unfilled or invalidated load, a fill aimed at a store slot, a flush in the same cycle as an enqueue, an enqueue attempt on a full queue, and a wrap of the pointers after draining. Each of these catches a design that takes a stale value or overwrites a slot that should stay untouched.

// File: rtl/lsq_sd_pkg.sv
package lsq_sd_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

endpackage

// File: rtl/lsq_sd_ctrl.sv
module lsq_sd_ctrl
    import lsq_sd_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_req,
    input  logic             deq_req,
    output logic             enq_fire,
    output logic             deq_fire,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             empty,
    output logic             full
);

    q_state_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] head_q, tail_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // transitions
    always_comb begin
        enq_fire = enq_req && (state_q != Q_FULL);
        deq_fire = deq_req && (state_q != Q_EMPTY);
        state_d  = state_q;
        unique case (state_q)
            Q_EMPTY: if (enq_fire) state_d = Q_PART;
            Q_PART: begin
                if (enq_fire && !deq_fire && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = Q_FULL;
                else if (deq_fire && !enq_fire && cnt_q == CNT_W'(1))
                    state_d = Q_EMPTY;
            end
            Q_FULL:  if (deq_fire) state_d = Q_PART;
            default: state_d = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (enq_fire) tail_q <= step(tail_q);
            if (deq_fire) head_q <= step(head_q);
            if (enq_fire && !deq_fire)      cnt_q <= cnt_q + 1'b1;
            else if (deq_fire && !enq_fire) cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        head  = head_q;
        tail  = tail_q;
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            Q_EMPTY: empty = 1'b1;
            Q_PART:  ;
            Q_FULL:  full  = 1'b1;
            default: empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsq_sd_entries.sv
module lsq_sd_entries #(
    parameter int DEPTH   = 32,
    parameter int WADDR_W = 16,
    parameter int BYTES   = 4,
    localparam int DATA_W = 8 * BYTES,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enq_fire,
    input  logic [IDX_W-1:0]               tail,
    input  logic                           enq_is_store,
    input  logic [WADDR_W-1:0]             enq_waddr,
    input  logic [BYTES-1:0]               enq_be,
    input  logic [DATA_W-1:0]              enq_data,
    input  logic                           enq_verdict,
    input  logic                           deq_fire,
    input  logic [IDX_W-1:0]               head,
    input  logic                           fill_valid,
    input  logic [IDX_W-1:0]               fill_slot,
    input  logic [DATA_W-1:0]              fill_data,
    input  logic                           flush,
    input  logic                           inval,
    output logic [DEPTH-1:0]               valid_vec,
    output logic [DEPTH-1:0]               store_vec,
    output logic [DEPTH-1:0]               known_vec,
    output logic [DEPTH-1:0]               silent_vec,
    output logic [DEPTH-1:0][WADDR_W-1:0]  addr_arr,
    output logic [DEPTH-1:0][BYTES-1:0]    be_arr,
    output logic [DEPTH-1:0][DATA_W-1:0]   data_arr
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic               vld_q, st_q, known_q, sil_q;
        logic [WADDR_W-1:0] addr_q;
        logic [BYTES-1:0]   be_q;
        logic [DATA_W-1:0]  val_q;
        logic               take_enq, take_deq, take_fill;

        assign take_enq  = enq_fire && (tail == IDX_W'(i));
        assign take_deq  = deq_fire && (head == IDX_W'(i));
        assign take_fill = fill_valid && (fill_slot == IDX_W'(i)) &&
                           vld_q && !st_q && !flush && !inval;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q   <= 1'b0;
                st_q    <= 1'b0;
                known_q <= 1'b0;
                sil_q   <= 1'b0;
                addr_q  <= '0;
                be_q    <= '0;
                val_q   <= '0;
            end else if (take_enq) begin
                vld_q   <= 1'b1;
                st_q    <= enq_is_store;
                known_q <= enq_is_store;
                sil_q   <= enq_verdict;
                addr_q  <= enq_waddr;
                be_q    <= enq_be;
                val_q   <= enq_data;
            end else if (take_deq) begin
                vld_q   <= 1'b0;
                known_q <= 1'b0;
                sil_q   <= 1'b0;
            end else if (flush) begin
                known_q <= 1'b0;
            end else if (inval && !st_q) begin
                known_q <= 1'b0;
            end else if (take_fill) begin
                known_q <= 1'b1;
                val_q   <= fill_data;
            end
        end

        assign valid_vec[i]  = vld_q;
        assign store_vec[i]  = st_q;
        assign known_vec[i]  = known_q;
        assign silent_vec[i] = sil_q;
        assign addr_arr[i]   = addr_q;
        assign be_arr[i]     = be_q;
        assign data_arr[i]   = val_q;
    end

endmodule

// File: rtl/lsq_sd_search.sv
module lsq_sd_search #(
    parameter int DEPTH   = 32,
    parameter int WADDR_W = 16,
    parameter int BYTES   = 4,
    localparam int DATA_W = 8 * BYTES,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]               head,
    input  logic [DEPTH-1:0]               valid_vec,
    input  logic [DEPTH-1:0]               store_vec,
    input  logic [DEPTH-1:0]               known_vec,
    input  logic [DEPTH-1:0][WADDR_W-1:0]  addr_arr,
    input  logic [DEPTH-1:0][BYTES-1:0]    be_arr,
    input  logic [DEPTH-1:0][DATA_W-1:0]   data_arr,
    input  logic                           new_is_store,
    input  logic [WADDR_W-1:0]             new_waddr,
    input  logic [BYTES-1:0]               new_be,
    input  logic [DATA_W-1:0]              new_data,
    input  logic                           flush,
    input  logic                           inval,
    output logic                           verdict
);

    logic             found;
    logic [IDX_W-1:0] src;
    logic             src_known, covered, differs;

    function automatic logic [IDX_W-1:0] age_slot(input logic [IDX_W-1:0] h, input int k);
        int t;
        t = int'(h) + k;
        if (t >= DEPTH) t = t - DEPTH;
        return IDX_W'(t);
    endfunction

    // oldest to youngest; the last overlap seen is the youngest one
    always_comb begin
        found = 1'b0;
        src   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (valid_vec[age_slot(head, k)] &&
                addr_arr[age_slot(head, k)] == new_waddr &&
                |(be_arr[age_slot(head, k)] & new_be)) begin
                found = 1'b1;
                src   = age_slot(head, k);
            end
        end
    end

    always_comb begin
        src_known = known_vec[src] && !flush && !(inval && !store_vec[src]);
        covered   = ((new_be & ~be_arr[src]) == '0);
        differs   = 1'b0;
        for (int b = 0; b < BYTES; b++) begin
            if (new_be[b] && (new_data[8*b +: 8] != data_arr[src][8*b +: 8]))
                differs = 1'b1;
        end
        verdict = new_is_store && found && src_known && covered && !differs;
    end

endmodule

// File: rtl/lsq_silent_detect.sv
module lsq_silent_detect #(
    parameter int DEPTH   = 32,
    parameter int WADDR_W = 16,
    parameter int BYTES   = 4,
    localparam int DATA_W = 8 * BYTES,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    output logic               enq_ready,
    input  logic               enq_is_store,
    input  logic [WADDR_W-1:0] enq_waddr,
    input  logic [BYTES-1:0]   enq_be,
    input  logic [DATA_W-1:0]  enq_data,
    output logic [IDX_W-1:0]   enq_slot,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_slot,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic               deq_valid,
    output logic               deq_silent,
    input  logic               barrier_flush,
    input  logic               coh_inval,
    output logic [DEPTH-1:0]   silent_vec,
    output logic               q_empty,
    output logic               q_full
);

    logic                          enq_fire, deq_fire, verdict;
    logic [IDX_W-1:0]              head, tail;
    logic [DEPTH-1:0]              valid_vec, store_vec, known_vec;
    logic [DEPTH-1:0][WADDR_W-1:0] addr_arr;
    logic [DEPTH-1:0][BYTES-1:0]   be_arr;
    logic [DEPTH-1:0][DATA_W-1:0]  data_arr;

    lsq_sd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq_req  (enq_valid),
        .deq_req  (deq_valid),
        .enq_fire (enq_fire),
        .deq_fire (deq_fire),
        .head     (head),
        .tail     (tail),
        .empty    (q_empty),
        .full     (q_full)
    );

    lsq_sd_search #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .BYTES(BYTES)) u_search (
        .head         (head),
        .valid_vec    (valid_vec),
        .store_vec    (store_vec),
        .known_vec    (known_vec),
        .addr_arr     (addr_arr),
        .be_arr       (be_arr),
        .data_arr     (data_arr),
        .new_is_store (enq_is_store),
        .new_waddr    (enq_waddr),
        .new_be       (enq_be),
        .new_data     (enq_data),
        .flush        (barrier_flush),
        .inval        (coh_inval),
        .verdict      (verdict)
    );

    lsq_sd_entries #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .BYTES(BYTES)) u_entries (
        .clk          (clk),
        .rst_n        (rst_n),
        .enq_fire     (enq_fire),
        .tail         (tail),
        .enq_is_store (enq_is_store),
        .enq_waddr    (enq_waddr),
        .enq_be       (enq_be),
        .enq_data     (enq_data),
        .enq_verdict  (verdict),
        .deq_fire     (deq_fire),
        .head         (head),
        .fill_valid   (fill_valid),
        .fill_slot    (fill_slot),
        .fill_data    (fill_data),
        .flush        (barrier_flush),
        .inval        (coh_inval),
        .valid_vec    (valid_vec),
        .store_vec    (store_vec),
        .known_vec    (known_vec),
        .silent_vec   (silent_vec),
        .addr_arr     (addr_arr),
        .be_arr       (be_arr),
        .data_arr     (data_arr)
    );

    assign enq_ready  = !q_full;
    assign enq_slot   = tail;
    assign deq_silent = silent_vec[head];

endmodule

// File: rtl/lsq_silent_detect_chk.sv
module lsq_silent_detect_chk #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             enq_ready,
    input logic             enq_is_store,
    input logic [IDX_W-1:0] enq_slot,
    input logic             deq_valid,
    input logic             barrier_flush,
    input logic [DEPTH-1:0] silent_vec,
    input logic             q_empty,
    input logic             q_full
);

    assert_empty_full_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_empty && q_full));

    assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !enq_ready);

    assert_ready_when_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !q_full |-> enq_ready);

    assert_empty_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (silent_vec == '0));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(enq_valid && enq_ready) && !deq_valid) |=> $stable(silent_vec));

    assert_one_set_one_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid || deq_valid) |=> ($countones(silent_vec ^ $past(silent_vec)) <= 2));

    assert_load_never_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready && !enq_is_store) |=> !silent_vec[$past(enq_slot)]);

    assert_flush_enq_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready && barrier_flush) |=> !silent_vec[$past(enq_slot)]);

endmodule

bind lsq_silent_detect lsq_silent_detect_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enq_valid     (enq_valid),
    .enq_ready     (enq_ready),
    .enq_is_store  (enq_is_store),
    .enq_slot      (enq_slot),
    .deq_valid     (deq_valid),
    .barrier_flush (barrier_flush),
    .silent_vec    (silent_vec),
    .q_empty       (q_empty),
    .q_full        (q_full)
);

// File: tb/lsq_silent_detect_bench.sv
`timescale 1ns/1ps
module lsq_silent_detect_bench;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0, enq_is_store = 1'b0;
    logic [15:0] enq_waddr = '0;
    logic [3:0]  enq_be = '0;
    logic [31:0] enq_data = '0;
    logic        fill_valid = 1'b0;
    logic [4:0]  fill_slot = '0;
    logic [31:0] fill_data = '0;
    logic        deq_valid = 1'b0, barrier_flush = 1'b0, coh_inval = 1'b0;
    logic        enq_ready, deq_silent, q_empty, q_full;
    logic [4:0]  enq_slot;
    logic [DEPTH-1:0] silent_vec;

    lsq_silent_detect u_lsq_silent_detect (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_is_store(enq_is_store), .enq_waddr(enq_waddr), .enq_be(enq_be),
        .enq_data(enq_data), .enq_slot(enq_slot), .fill_valid(fill_valid),
        .fill_slot(fill_slot), .fill_data(fill_data), .deq_valid(deq_valid),
        .deq_silent(deq_silent), .barrier_flush(barrier_flush), .coh_inval(coh_inval),
        .silent_vec(silent_vec), .q_empty(q_empty), .q_full(q_full)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int    mon_slot[$];
    bit    mon_exp[$];
    string mon_tag[$];
    bit    deq_exp[$];
    string deq_tag[$];
    int    last_slot;
    int    ms;
    bit    me;
    string mt;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // driver: enqueue one op and record what the flag should become
    task automatic enq_op(input bit st, input logic [15:0] a, input logic [3:0] be,
                          input logic [31:0] d, input bit exp, input string tag,
                          input bit fl = 1'b0);
        @(negedge clk);
        enq_valid = 1'b1; enq_is_store = st; enq_waddr = a; enq_be = be;
        enq_data = d; barrier_flush = fl;
        last_slot = int'(enq_slot);
        @(posedge clk); #1;
        enq_valid = 1'b0; barrier_flush = 1'b0;
        mon_slot.push_back(last_slot); mon_exp.push_back(exp); mon_tag.push_back(tag);
        deq_exp.push_back(exp); deq_tag.push_back(tag);
    endtask

    task automatic fill_op(input int s, input logic [31:0] d);
        @(negedge clk);
        fill_valid = 1'b1; fill_slot = 5'(s); fill_data = d;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic pulse(input bit is_flush);
        @(negedge clk);
        if (is_flush) barrier_flush = 1'b1; else coh_inval = 1'b1;
        @(posedge clk); #1;
        barrier_flush = 1'b0; coh_inval = 1'b0;
    endtask

    task automatic deq_op();
        @(negedge clk);
        check({"R9 deq order ", deq_tag[0]}, int'(deq_silent), int'(deq_exp[0]));
        void'(deq_exp.pop_front()); void'(deq_tag.pop_front());
        deq_valid = 1'b1;
        @(posedge clk); #1;
        deq_valid = 1'b0;
    endtask

    // monitor: compare each enqueued slot's flag one half cycle after its edge
    always @(negedge clk) begin
        while (mon_slot.size() > 0) begin
            ms = mon_slot.pop_front(); me = mon_exp.pop_front(); mt = mon_tag.pop_front();
            check(mt, int'(silent_vec[ms]), int'(me));
        end
    end

    initial begin
        int sF, sG, sJ;
        logic [DEPTH-1:0] snap;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty", int'(q_empty), 1);
        check("R1 full", int'(q_full), 0);
        check("R1 ready", int'(enq_ready), 1);
        check("R1 flags", int'(silent_vec), 0);

        // same-word store chain
        enq_op(1, 16'h10, 4'hF, 32'h0000_1111, 0, "R2 first store");
        enq_op(1, 16'h10, 4'hF, 32'h0000_1111, 1, "R2 same data");
        enq_op(1, 16'h10, 4'h3, 32'hABCD_1111, 1, "R2 covered subset");
        enq_op(1, 16'h10, 4'h3, 32'h0000_2222, 0, "R4 data differs");
        enq_op(1, 16'h10, 4'h3, 32'h0000_1111, 0, "R5 younger blocks");

        // byte coverage
        enq_op(1, 16'h20, 4'h3, 32'h0000_5555, 0, "R6 partial first");
        enq_op(1, 16'h20, 4'hF, 32'h0000_5555, 0, "R6 source not covering");
        enq_op(1, 16'h30, 4'hF, 32'h4433_2211, 0, "R6 base store");
        enq_op(1, 16'h30, 4'h8, 32'h9900_0000, 0, "R4 top byte differs");
        enq_op(1, 16'h30, 4'h1, 32'h0000_0011, 1, "R6 non-overlap skipped");

        // loads as sources
        enq_op(0, 16'h50, 4'hF, 32'h0, 0, "R7 load not flagged");
        enq_op(1, 16'h50, 4'hF, 32'h0, 0, "R7 unfilled load");
        enq_op(0, 16'h60, 4'hF, 32'h0, 0, "R7 load F");
        sF = last_slot;
        fill_op(sF, 32'hCAFE_F00D);
        enq_op(1, 16'h60, 4'hF, 32'hCAFE_F00D, 1, "R3 filled load");
        enq_op(0, 16'h70, 4'hF, 32'h0, 0, "R7 load G");
        sG = last_slot;
        fill_op(sG, 32'h0000_0010);
        pulse(1'b0);
        enq_op(1, 16'h70, 4'hF, 32'h0000_0010, 0, "R7 invalidated load");
        enq_op(1, 16'h80, 4'hF, 32'h0000_0055, 0, "R7 store H");
        pulse(1'b0);
        enq_op(1, 16'h80, 4'hF, 32'h0000_0055, 1, "R7 store survives inval");
        enq_op(1, 16'h90, 4'hF, 32'h0000_0066, 0, "R11 store J");
        sJ = last_slot;
        fill_op(sJ, 32'h0000_0077);
        enq_op(1, 16'h90, 4'hF, 32'h0000_0066, 1, "R11 fill to store ignored");

        // barrier
        enq_op(1, 16'hA0, 4'hF, 32'h0000_0088, 0, "R8 store K");
        pulse(1'b1);
        @(negedge clk);
        check("R8 flag kept", int'(silent_vec[1]), 1);
        enq_op(1, 16'hA0, 4'hF, 32'h0000_0088, 0, "R8 after flush");
        enq_op(1, 16'hB0, 4'hF, 32'h0000_0099, 0, "R8 store K2");
        enq_op(1, 16'hB0, 4'hF, 32'h0000_0099, 0, "R8 flush same cycle", 1'b1);

        // fill to capacity
        for (int i = 0; i < 8; i++)
            enq_op(1, 16'h100 + 16'(i), 4'hF, 32'(i), 0, "R10 fill queue");
        @(negedge clk);
        check("R10 full", int'(q_full), 1);
        check("R10 not ready", int'(enq_ready), 0);
        snap = silent_vec;
        enq_valid = 1'b1; enq_is_store = 1'b1; enq_waddr = 16'h10;
        enq_be = 4'h3; enq_data = 32'h0000_2222;
        @(posedge clk); #1;
        enq_valid = 1'b0;
        @(negedge clk);
        check("R10 blocked enqueue flags", int'(silent_vec == snap), 1);
        check("R10 still full", int'(q_full), 1);

        // drain in order
        for (int i = 0; i < DEPTH; i++) deq_op();
        @(negedge clk);
        check("R9 empty after drain", int'(q_empty), 1);
        check("R9 flags cleared", int'(silent_vec), 0);

        // pointers wrapped
        enq_op(1, 16'h200, 4'hF, 32'h0000_0005, 0, "R2 wrap first");
        enq_op(1, 16'h200, 4'hF, 32'h0000_0005, 1, "R2 wrap repeat");
        deq_op();
        deq_op();
        repeat (2) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            check("watchdog", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule